// File: doc/BRIEF.md
# Multi-Match Priority Resolver with Next-Advance

This block sits behind a content-addressable array. When a comparison finishes, it captures the per-entry hit vector. It then reports the address of the lowest-indexed hit, which is the highest-priority match. It also reports whether more than one hit remains. An "advance" instruction retires the address being reported and moves to the following hit in the same clock. Once every hit has been retired, an active-low match flag rises HIGH.

Several devices can be stacked vertically using an active-low priority chain. A device only responds to advance instructions while its chain input is HIGH, meaning no device above it still holds matches. Its chain output stays LOW while the device itself, or any device above it, still has matches. This lets one advance instruction, broadcast to every device, step through the whole stack in priority order.

Top module: `mm_resolver`

## Requirements
- R1: After a synchronous active-high reset, the stored hit set is empty. `match_flag_n` is HIGH, `multi_flag` is LOW and `match_addr` is 0.
- R2: When `cmp_load` is HIGH at a clock edge, `match_vec` is captured. From the next cycle, `match_addr` is the index of the lowest set bit, and `match_flag_n` is LOW if any bit is set.
- R3: `multi_flag` is HIGH exactly when two or more hits remain in the stored set.
- R4: An advance is accepted when all of the following hold: `insn_valid` is HIGH, `insn[5:0]` equals 6'b011011, `half_sel` is LOW, `chain_in_n` is HIGH and `cmp_load` is LOW. The reported hit is then cleared, and the next cycle reports the next higher set index.
- R5: An advance with `half_sel` HIGH, or any other `insn` code (for example 6'b011000), leaves the stored set and every output unchanged.
- R6: When the last hit is retired, `match_flag_n` goes HIGH and `match_addr` returns to 0. Further advances on an empty set change nothing.
- R7: While `chain_in_n` is LOW, advances are ignored and `match_addr` holds its value.
- R8: `chain_out_n` is LOW whenever `chain_in_n` is LOW or a local hit remains. Otherwise it is HIGH. It responds in the same cycle.
- R9: When `cmp_load` and an advance occur together, the load wins: the new vector is captured unmodified.
- R10: Loading an all-zero vector gives `match_flag_n` HIGH, `multi_flag` LOW and `match_addr` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_load | input | 1 | Capture `match_vec` at this edge |
| match_vec | input | ENTRIES | Per-entry hit vector from the comparison |
| insn_valid | input | 1 | `insn` carries an instruction this cycle |
| insn | input | 6 | Instruction function code |
| half_sel | input | 1 | Half-word select; must be LOW for an advance |
| chain_in_n | input | 1 | LOW while a higher device still has matches |
| match_addr | output | AW | Address of the highest-priority remaining hit |
| match_flag_n | output | 1 | LOW while any local hit remains |
| multi_flag | output | 1 | Two or more local hits remain |
| chain_out_n | output | 1 | LOW while this device or one above has matches |

## Verification
A stored hit set that has gone wrong shows up at the ports one cycle after the edge that corrupted it. A bit that was dropped early makes `match_addr` skip an index on the next advance. A bit that fails to clear makes `match_addr` repeat, and keeps `multi_flag` or `match_flag_n` in a stale state. A broken gating term in the advance decode shows as an address change in the cycle after an instruction that should have been ignored. A broken chain term shows in the same cycle on `chain_out_n`.

// File: rtl/mm_pkg.sv
package mm_pkg;

    localparam int INSN_W = 6;
    localparam logic [INSN_W-1:0] INSN_ADVANCE = 6'b011011;

    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_LOAD    = 2'd1,
        ACT_ADVANCE = 2'd2
    } mm_action_e;

    function automatic logic is_advance(input logic [INSN_W-1:0] code,
                                        input logic valid,
                                        input logic half);
        return valid && (code == INSN_ADVANCE) && !half;
    endfunction

endpackage

// File: rtl/mm_first_set.sv
module mm_first_set #(
    parameter int N  = 16,
    parameter int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [N-1:0]  onehot,
    output logic [AW-1:0] addr,
    output logic          any,
    output logic          more
);

    logic [N:0] below;

    assign below[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_scan
        assign onehot[g]  = vec[g] & ~below[g];
        assign below[g+1] = below[g] | vec[g];
    end

    always_comb begin
        addr = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) addr = addr | AW'(i);
        end
    end

    assign any  = below[N];
    assign more = |(vec & ~onehot);

endmodule

// File: rtl/mm_action_decode.sv
module mm_action_decode
    import mm_pkg::*;
(
    input  logic              cmp_load,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic              half_sel,
    input  logic              chain_in_n,
    input  logic              has_hit,
    output mm_action_e        action
);

    always_comb begin
        if (cmp_load) begin
            action = ACT_LOAD;
        end else if (is_advance(insn, insn_valid, half_sel) && chain_in_n && has_hit) begin
            action = ACT_ADVANCE;
        end else begin
            action = ACT_HOLD;
        end
    end

endmodule

// File: rtl/mm_hit_store.sv
module mm_hit_store
    import mm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  mm_action_e    action,
    input  logic [N-1:0]  load_vec,
    input  logic [N-1:0]  retire_mask,
    output logic [N-1:0]  hits
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hits <= '0;
        end else begin
            unique case (action)
                ACT_LOAD:    hits <= load_vec;
                ACT_ADVANCE: hits <= hits & ~retire_mask;
                default:     hits <= hits;
            endcase
        end
    end

endmodule

// File: rtl/mm_resolver.sv
module mm_resolver
    import mm_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmp_load,
    input  logic [ENTRIES-1:0] match_vec,
    input  logic               insn_valid,
    input  logic [INSN_W-1:0]  insn,
    input  logic               half_sel,
    input  logic               chain_in_n,
    output logic [AW-1:0]      match_addr,
    output logic               match_flag_n,
    output logic               multi_flag,
    output logic               chain_out_n
);

    logic [ENTRIES-1:0] hits;
    logic [ENTRIES-1:0] head;
    logic               any_hit;
    logic               many_hit;
    mm_action_e         action;

    mm_first_set #(.N(ENTRIES), .AW(AW)) i_enc (
        .vec    (hits),
        .onehot (head),
        .addr   (match_addr),
        .any    (any_hit),
        .more   (many_hit)
    );

    mm_action_decode i_dec (
        .cmp_load   (cmp_load),
        .insn_valid (insn_valid),
        .insn       (insn),
        .half_sel   (half_sel),
        .chain_in_n (chain_in_n),
        .has_hit    (any_hit),
        .action     (action)
    );

    mm_hit_store #(.N(ENTRIES)) i_store (
        .clk         (clk),
        .rst         (rst),
        .action      (action),
        .load_vec    (match_vec),
        .retire_mask (head),
        .hits        (hits)
    );

    assign match_flag_n = ~any_hit;
    assign multi_flag   = many_hit;
    assign chain_out_n  = chain_in_n & ~any_hit;

endmodule

// File: rtl/mm_resolver_chk.sv
module mm_resolver_chk
    import mm_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               cmp_load,
    input logic [ENTRIES-1:0] match_vec,
    input logic               insn_valid,
    input logic [INSN_W-1:0]  insn,
    input logic               half_sel,
    input logic               chain_in_n,
    input logic [AW-1:0]      match_addr,
    input logic               match_flag_n,
    input logic               multi_flag,
    input logic               chain_out_n
);

    logic adv_req;
    assign adv_req = insn_valid && (insn == INSN_ADVANCE) && !half_sel && chain_in_n && !cmp_load;

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (match_flag_n && !multi_flag && match_addr == '0));

    // R2
    load_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_load && |match_vec) |=> !match_flag_n);

    // R3
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
        multi_flag |-> !match_flag_n);

    // R4
    advance_keeps_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_req && multi_flag) |=> !match_flag_n);

    // R6
    last_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_req && !match_flag_n && !multi_flag) |=> match_flag_n);

    // R7
    chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!chain_in_n && !cmp_load) |=> $stable(match_addr));

    // R8
    chain_upper_chk: assert property (@(posedge clk) disable iff (rst)
        !chain_in_n |-> !chain_out_n);

    // R8
    chain_local_chk: assert property (@(posedge clk) disable iff (rst)
        !match_flag_n |-> !chain_out_n);

    // R10
    load_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_load && match_vec == '0) |=> (match_flag_n && match_addr == '0));

endmodule

bind mm_resolver mm_resolver_chk #(.ENTRIES(ENTRIES)) i_chk (.*);

// File: tb/test_mm_resolver.sv
module test_mm_resolver;

    localparam int N  = 16;
    localparam int AW = 4;

    localparam logic [1:0] OP_NOP = 2'd0;
    localparam logic [1:0] OP_LD  = 2'd1;
    localparam logic [1:0] OP_ADV = 2'd2;
    localparam logic [1:0] OP_CMP = 2'd3;

    typedef struct packed {
        logic [1:0]    op;
        logic [N-1:0]  vec;
        logic          hsel;
        logic          cin;
        logic [AW-1:0] addr;
        logic          flag_n;
        logic          multi;
        logic          cout;
    } row_t;

    localparam int ROWS = 13;
    localparam row_t TBL [ROWS] = '{
        '{OP_LD,  16'h8124, 1'b0, 1'b1, 4'd2,  1'b0, 1'b1, 1'b0}, // R2 R3
        '{OP_ADV, 16'h0000, 1'b0, 1'b1, 4'd5,  1'b0, 1'b1, 1'b0}, // R4
        '{OP_ADV, 16'h0000, 1'b1, 1'b1, 4'd5,  1'b0, 1'b1, 1'b0}, // R5
        '{OP_ADV, 16'h0000, 1'b0, 1'b0, 4'd5,  1'b0, 1'b1, 1'b0}, // R7
        '{OP_CMP, 16'h0000, 1'b0, 1'b1, 4'd5,  1'b0, 1'b1, 1'b0}, // R5
        '{OP_ADV, 16'h0000, 1'b0, 1'b1, 4'd8,  1'b0, 1'b1, 1'b0}, // R4
        '{OP_ADV, 16'h0000, 1'b0, 1'b1, 4'd15, 1'b0, 1'b0, 1'b0}, // R3
        '{OP_ADV, 16'h0000, 1'b0, 1'b1, 4'd0,  1'b1, 1'b0, 1'b1}, // R6
        '{OP_ADV, 16'h0000, 1'b0, 1'b1, 4'd0,  1'b1, 1'b0, 1'b1}, // R6
        '{OP_NOP, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 1'b0}, // R8
        '{OP_LD,  16'h0001, 1'b0, 1'b1, 4'd0,  1'b0, 1'b0, 1'b0}, // R2
        '{OP_LD,  16'h0000, 1'b0, 1'b1, 4'd0,  1'b1, 1'b0, 1'b1}, // R10
        '{OP_LD,  16'hC000, 1'b0, 1'b1, 4'd14, 1'b0, 1'b1, 1'b0}  // R2 R3
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          cmp_load;
    logic [N-1:0]  match_vec;
    logic          insn_valid;
    logic [5:0]    insn;
    logic          half_sel;
    logic          chain_in_n;
    logic [AW-1:0] match_addr;
    logic          match_flag_n;
    logic          multi_flag;
    logic          chain_out_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mm_resolver #(.ENTRIES(N)) i_mm_resolver (
        .clk          (clk),
        .rst          (rst),
        .cmp_load     (cmp_load),
        .match_vec    (match_vec),
        .insn_valid   (insn_valid),
        .insn         (insn),
        .half_sel     (half_sel),
        .chain_in_n   (chain_in_n),
        .match_addr   (match_addr),
        .match_flag_n (match_flag_n),
        .multi_flag   (multi_flag),
        .chain_out_n  (chain_out_n)
    );

    task automatic check(input string req, input logic [AW-1:0] ea,
                         input logic ef, input logic em, input logic ec);
        checks++;
        if (match_addr !== ea || match_flag_n !== ef || multi_flag !== em || chain_out_n !== ec) begin
            errors++;
            $display("FAIL %s: got addr=%0d flag_n=%b multi=%b cout=%b, expected addr=%0d flag_n=%b multi=%b cout=%b",
                     req, match_addr, match_flag_n, multi_flag, chain_out_n, ea, ef, em, ec);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [N-1:0] v,
                         input logic hs, input logic ci);
        @(negedge clk);
        cmp_load   = (op == OP_LD);
        match_vec  = v;
        insn_valid = (op == OP_ADV) || (op == OP_CMP);
        insn       = (op == OP_CMP) ? 6'b011000 : 6'b011011;
        half_sel   = hs;
        chain_in_n = ci;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1; cmp_load = 1'b0; match_vec = '0; insn_valid = 1'b0;
        insn = '0; half_sel = 1'b0; chain_in_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 4'd0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < ROWS; k++) begin
            drive(TBL[k].op, TBL[k].vec, TBL[k].hsel, TBL[k].cin);
            check($sformatf("row %0d (R2-R10 table)", k), TBL[k].addr, TBL[k].flag_n,
                  TBL[k].multi, TBL[k].cout);
        end

        // R9: load together with an advance keeps the new vector intact
        @(negedge clk);
        cmp_load = 1'b1; match_vec = 16'h0030; insn_valid = 1'b1;
        insn = 6'b011011; half_sel = 1'b0; chain_in_n = 1'b1;
        @(posedge clk);
        #1;
        check("R9 load beats advance", 4'd4, 1'b0, 1'b1, 1'b0);

        // R8: upper device busy forces chain out low even with local hits
        drive(OP_NOP, '0, 1'b0, 1'b0);
        check("R8 chain pass", 4'd4, 1'b0, 1'b1, 1'b0);

        // R4: walk to last then exhaust
        drive(OP_ADV, '0, 1'b0, 1'b1);
        check("R4 advance to 5", 4'd5, 1'b0, 1'b0, 1'b0);
        drive(OP_ADV, '0, 1'b0, 1'b1);
        check("R6 exhausted", 4'd0, 1'b1, 1'b0, 1'b1);

        // R1: reset in the middle of a walk
        drive(OP_LD, 16'h00F0, 1'b0, 1'b1);
        check("R2 reload", 4'd4, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        cmp_load = 1'b0; insn_valid = 1'b0; rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", 4'd0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule